// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the receive-side front end of an I2C target. It takes raw SCL and SDA from the pads and passes each through a register synchronizer. It then finds the bus conditions by comparing successive registered samples against the system clock. From these it keeps a bus-busy flag and shifts in each byte with the most significant bit arriving first.

After a START, the first byte is compared with the block's own address. A mode input selects how: either a 7-bit address with a direction bit, or a two-byte 10-bit address. The block acknowledges a matching address, and each byte written to it, by enabling an open-drain pull-down on SDA for the ninth clock. Received bytes are presented with a one-cycle strobe. A repeated START while busy restarts address decoding. In 10-bit mode, that repeated START allows a short read header to be accepted once the full address has matched.

The system clock must run at least eight times faster than SCL.

Top module: `i2c_addr_match`

## Requirements
- R1: A START (the synchronized SDA going from 1 to 0 while the synchronized SCL stays 1) produces a one-cycle `startPulse`. `busy` is 1 from the following cycle.
- R2: A STOP (the synchronized SDA going from 0 to 1 while the synchronized SCL stays 1) produces a one-cycle `stopPulse`. It ends any transfer.
- R3: `busy` is cleared after a STOP. A repeated START while busy leaves `busy` at 1.
- R4: Bits are taken on SCL rising edges, most significant bit first. An SDA change while SCL is low is never reported as a START or a STOP.
- R5: With `tenBitMode`=0, bits 7:1 of the first byte after a START are compared with `ownAddr[6:0]`, and bit 0 is the direction (1 = read). On a match the byte is acknowledged, `addrMatch` goes to 1 and `rwBit` holds the direction until the next START or STOP.
- R6: After a write address match, each further byte is acknowledged and appears on `rxData` with a one-cycle `rxValid`.
- R7: When the first byte does not match, SDA stays released in the ninth clock. No later byte is acknowledged or strobed out until the next START, and `addrMatch` stays 0.
- R8: With `tenBitMode`=1, a first byte of 5'b11110, then `ownAddr[9:8]`, then 0 is acknowledged without setting `addrMatch`. The second byte is acknowledged, and sets `addrMatch`, only when it equals `ownAddr[7:0]`. A first byte with another prefix or other upper bits is not acknowledged.
- R9: In 10-bit mode, after a full address match, a repeated START followed by 5'b11110, `ownAddr[9:8]`, 1 is acknowledged as a read match with `rwBit`=1. Without a prior full match in the same busy period, that byte is not acknowledged.
- R10: `sdaOe` rises after the SCL falling edge that ends bit 8 of an acknowledged byte. It falls after the SCL falling edge that ends the ninth clock. It is 0 during the data bits.
- R11: After reset, `busy`, `sdaOe`, `addrMatch`, `rxValid`, `startPulse` and `stopPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Raw SCL from the pad |
| sdaIn | input | 1 | Raw SDA from the pad |
| tenBitMode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| ownAddr | input | 10 | Own address; 7-bit mode uses bits 6:0 |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | output | 1 | Bus busy between START and STOP |
| startPulse | output | 1 | One-cycle START indication |
| stopPulse | output | 1 | One-cycle STOP indication |
| addrMatch | output | 1 | Own address matched in the current transfer |
| rwBit | output | 1 | Direction bit of the matched address (1 = read) |
| rxData | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle strobe for a new `rxData` |

## Verification
The bench drives an open-drain bus model and reads the acknowledge bit from the wired line in the ninth clock. A wrong address compare therefore shows up as a missing or extra acknowledge. The 10-bit cases are:
- a correct header followed by a wrong low byte, which a design that matched on the header alone would wrongly acknowledge;
- a wrong upper-bit header;
- a read header without a prior full match, which a design that never cleared its memory of the full match would acknowledge;
- a repeated START, where a design that cleared `busy` or reused a stale bit count would decode the read header incorrectly.

A data byte with alternating bits toggles SDA while SCL is low; a design that missed the SCL-high qualifier would report spurious START or STOP pulses. The release of `sdaOe` is checked in the low phase after the ninth clock; a late release would hold the line during the next bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef struct packed {
    logic clrBits;
    logic loadData;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR1,
    S_ADDR2,
    S_DATA,
    S_READ,
    S_IGNORE
  } matchState_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobes_t      ctrl,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic              ackDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  assign rawLines = {sclIn, sdaIn};

  // One synchronizer chain per bus line; the idle level of both lines is 1.
  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[SYNC_STAGES-1];
  end

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = syncLines[1];
  assign sdaNow = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic sclRise, sclFall;
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctrl.clrBits) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt < CNT_W'(BYTE_W)) shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      if (bitCnt < CNT_W'(BYTE_W + 1)) bitCnt <= bitCnt + 1'b1;
    end else if (ackDone) begin
      bitCnt <= '0;
    end
  end

  assign byteDone = sclFall && (bitCnt == CNT_W'(BYTE_W));
  assign ackDone  = sclFall && (bitCnt == CNT_W'(BYTE_W + 1));
  assign rxByte   = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctrl.loadData;
      if (ctrl.loadData) rxData <= shiftReg;
    end
  end
endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tenBitMode,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic              ackDone,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStrobes_t      ctrl,
  output logic              sdaOe,
  output logic              busy,
  output logic              addrMatch,
  output logic              rwBit
);
  matchState_t state, nextState;
  logic tenMatched, tenNext;
  logic ackByte, setMatch, setRw, loadByte;
  logic headerOk;

  assign headerOk = (rxByte[7:3] == TEN_PREFIX) && (rxByte[2:1] == ownAddr[9:8]);

  always_comb begin
    nextState = state;
    ackByte   = 1'b0;
    setMatch  = 1'b0;
    setRw     = rwBit;
    loadByte  = 1'b0;
    tenNext   = tenMatched;
    case (state)
      S_ADDR1: begin
        if (!tenBitMode) begin
          if (rxByte[7:1] == ownAddr[6:0]) begin
            ackByte   = 1'b1;
            setMatch  = 1'b1;
            setRw     = rxByte[0];
            nextState = rxByte[0] ? S_READ : S_DATA;
          end else begin
            nextState = S_IGNORE;
          end
        end else if (headerOk && !rxByte[0]) begin
          ackByte   = 1'b1;
          setRw     = 1'b0;
          nextState = S_ADDR2;
        end else if (headerOk && tenMatched) begin
          ackByte   = 1'b1;
          setMatch  = 1'b1;
          setRw     = 1'b1;
          nextState = S_READ;
        end else begin
          nextState = S_IGNORE;
        end
      end
      S_ADDR2: begin
        if (rxByte == ownAddr[7:0]) begin
          ackByte   = 1'b1;
          setMatch  = 1'b1;
          tenNext   = 1'b1;
          nextState = S_DATA;
        end else begin
          nextState = S_IGNORE;
        end
      end
      S_DATA: begin
        ackByte  = 1'b1;
        loadByte = 1'b1;
      end
      default: ;
    endcase
    if (nextState == S_IGNORE) tenNext = 1'b0;
  end

  assign ctrl.clrBits  = startDet | stopDet;
  assign ctrl.loadData = byteDone & loadByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      busy       <= 1'b0;
      addrMatch  <= 1'b0;
      rwBit      <= 1'b0;
      tenMatched <= 1'b0;
      sdaOe      <= 1'b0;
    end else if (stopDet) begin
      state      <= S_IDLE;
      busy       <= 1'b0;
      addrMatch  <= 1'b0;
      tenMatched <= 1'b0;
      sdaOe      <= 1'b0;
    end else if (startDet) begin
      state     <= S_ADDR1;
      busy      <= 1'b1;
      addrMatch <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (byteDone) begin
      state      <= nextState;
      addrMatch  <= addrMatch | setMatch;
      rwBit      <= setRw;
      tenMatched <= tenNext;
      sdaOe      <= ackByte;
    end else if (ackDone) begin
      sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              tenBitMode,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              sdaOe,
  output logic              busy,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              addrMatch,
  output logic              rwBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid
);
  ctrlStrobes_t ctrl;
  logic startDet, stopDet, byteDone, ackDone;
  logic [BYTE_W-1:0] rxByte;

  i2cm_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctrl(ctrl),
    .startDet(startDet), .stopDet(stopDet), .byteDone(byteDone),
    .ackDone(ackDone), .rxByte(rxByte), .rxData(rxData), .rxValid(rxValid)
  );

  i2cm_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tenBitMode(tenBitMode), .ownAddr(ownAddr),
    .startDet(startDet), .stopDet(stopDet), .byteDone(byteDone),
    .ackDone(ackDone), .rxByte(rxByte), .ctrl(ctrl), .sdaOe(sdaOe),
    .busy(busy), .addrMatch(addrMatch), .rwBit(rwBit)
  );

  assign startPulse = startDet;
  assign stopPulse  = stopDet;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic sdaOe,
  input logic addrMatch,
  input logic rwBit,
  input logic rxValid,
  input logic startPulse,
  input logic stopPulse
);
  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> busy);

  assert_idle_after_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> (!busy && !addrMatch));

  assert_rx_needs_write_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (addrMatch && !rwBit));

  assert_rx_single_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_oe_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> busy);

  assert_match_only_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |-> busy);
endmodule

bind i2c_addr_match i2cm_checker u_chk (.*);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int QTR  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic tenBitMode = 1'b0;
  logic [9:0] ownAddr = 10'h05A;
  logic sdaOe, busy, startPulse, stopPulse, addrMatch, rwBit, rxValid;
  logic [7:0] rxData;
  wire sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .tenBitMode(tenBitMode), .ownAddr(ownAddr), .sdaOe(sdaOe), .busy(busy),
    .startPulse(startPulse), .stopPulse(stopPulse), .addrMatch(addrMatch),
    .rwBit(rwBit), .rxData(rxData), .rxValid(rxValid)
  );

  int nChecks = 0;
  int nFail = 0;
  int startCnt = 0;
  int stopCnt = 0;
  bit done = 1'b0;
  logic [7:0] expData[$];

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (startPulse) startCnt++;
    if (stopPulse) stopCnt++;
    if (rstN && rxValid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R6/R7 unexpected rxValid", rxData, 0);
      end else begin
        logic [7:0] e;
        e = expData.pop_front();
        check(rxData == e, "R6 rxData", rxData, e);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart();
    sdaDrv = 1'b1; waitClk(QTR);
    sclDrv = 1'b1; waitClk(HALF);
    sdaDrv = 1'b0; waitClk(HALF);
    sclDrv = 1'b0; waitClk(QTR);
  endtask

  task automatic doStop();
    sdaDrv = 1'b0; waitClk(QTR);
    sclDrv = 1'b1; waitClk(HALF);
    sdaDrv = 1'b1; waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit isData, input string req);
    if (isData && expAck) expData.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitClk(QTR);
      sclDrv = 1'b1; waitClk(HALF/2);
      if (i == 0) check(sdaOe == 1'b0, "R10 oe low in data bit", sdaOe, 0);
      waitClk(HALF/2);
      sclDrv = 1'b0; waitClk(QTR);
    end
    sdaDrv = 1'b1; waitClk(QTR);
    sclDrv = 1'b1; waitClk(HALF/2);
    check((sdaLine == 1'b0) == expAck, req, !sdaLine, expAck);
    waitClk(HALF/2);
    sclDrv = 1'b0; waitClk(QTR);
    check(sdaOe == 1'b0, "R10 oe released after ninth clock", sdaOe, 0);
  endtask

  task automatic checkDrained(input string req);
    check(expData.size() == 0, req, expData.size(), 0);
    expData.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int s0;
    waitClk(3);
    check(!busy && !sdaOe && !addrMatch && !rxValid && !startPulse && !stopPulse,
          "R11 reset state", {busy, sdaOe, addrMatch, rxValid}, 0);
    rstN = 1'b1;
    waitClk(5);

    // 7-bit write
    tenBitMode = 1'b0; ownAddr = 10'h05A;
    s0 = startCnt;
    doStart();
    check(startCnt == s0 + 1, "R1 start pulse", startCnt - s0, 1);
    check(busy == 1'b1, "R3 busy after start", busy, 1);
    sendByte({7'h5A, 1'b0}, 1'b1, 1'b0, "R5 7-bit address ack");
    check(addrMatch == 1'b1, "R5 addrMatch", addrMatch, 1);
    check(rwBit == 1'b0, "R5 rwBit write", rwBit, 0);
    sendByte(8'hA5, 1'b1, 1'b1, "R6 data ack");
    s0 = startCnt;
    sendByte(8'h55, 1'b1, 1'b1, "R6 data ack");
    check(startCnt == s0 && stopCnt == 0, "R4 no condition on low-phase toggles", startCnt - s0 + stopCnt, 0);
    sendByte(8'h3C, 1'b1, 1'b1, "R6 data ack");
    doStop();
    check(stopCnt == 1, "R2 stop pulse", stopCnt, 1);
    check(busy == 1'b0, "R3 busy cleared", busy, 0);
    check(addrMatch == 1'b0, "R2 match cleared by stop", addrMatch, 0);
    checkDrained("R6 all bytes delivered");

    // 7-bit mismatch
    doStart();
    sendByte({7'h5B, 1'b0}, 1'b0, 1'b0, "R7 mismatch no ack");
    sendByte(8'h12, 1'b0, 1'b1, "R7 later byte no ack");
    check(addrMatch == 1'b0, "R7 no match", addrMatch, 0);
    doStop();
    checkDrained("R7 nothing delivered");

    // 7-bit read
    doStart();
    sendByte({7'h5A, 1'b1}, 1'b1, 1'b0, "R5 read address ack");
    check(rwBit == 1'b1 && addrMatch, "R5 rwBit read", rwBit, 1);
    doStop();

    // 10-bit write then repeated-start read
    tenBitMode = 1'b1; ownAddr = 10'h2C7;
    doStart();
    sendByte(8'hF4, 1'b1, 1'b0, "R8 header ack");
    check(addrMatch == 1'b0, "R8 no match after header", addrMatch, 0);
    sendByte(8'hC7, 1'b1, 1'b0, "R8 low byte ack");
    check(addrMatch == 1'b1, "R8 full match", addrMatch, 1);
    sendByte(8'h81, 1'b1, 1'b1, "R6 10-bit data ack");
    s0 = startCnt;
    doStart();
    check(startCnt == s0 + 1 && busy, "R3 busy held on repeated start", busy, 1);
    sendByte(8'hF5, 1'b1, 1'b0, "R9 read header ack");
    check(addrMatch && rwBit, "R9 read match", {addrMatch, rwBit}, 3);
    doStop();
    checkDrained("R6 10-bit bytes delivered");

    // 10-bit wrong low byte
    doStart();
    sendByte(8'hF4, 1'b1, 1'b0, "R8 header ack");
    sendByte(8'hC6, 1'b0, 1'b0, "R8 wrong low byte no ack");
    sendByte(8'h77, 1'b0, 1'b1, "R7 data after mismatch no ack");
    doStop();

    // 10-bit read header without prior match
    doStart();
    sendByte(8'hF5, 1'b0, 1'b0, "R9 read header without match no ack");
    doStop();

    // 10-bit wrong upper bits
    doStart();
    sendByte(8'hF0, 1'b0, 1'b0, "R8 wrong upper bits no ack");
    check(addrMatch == 1'b0, "R8 no match", addrMatch, 0);
    doStop();
    checkDrained("R7 nothing after mismatches");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule